// File: doc/BRIEF.md
# Interval-Sampled Stall Monitor with Event Sequencer

This block watches a stall-trigger line from custom logic and counts how many clock cycles it is high during a sampling interval. The interval length can be changed at run time. When an interval expires, the block copies the running count to a sample output and marks it with a one-cycle valid strobe. The count then starts again for the next interval. A trace path downstream can collect these periodic samples and build a stall-rate profile over time.

Next to the counter is a three-state event sequencer. A memory-access event from a bus monitor moves it from idle into a "DMA started" state. A stall seen in that state moves it into a stall state. On that entry the block raises a one-cycle cross-trigger pulse, which other debug blocks can use to start capturing trace. The end of the current sampling interval returns the sequencer from the stall state to idle. A single enable input gates the whole block.

Top module: `ism_status_monitor`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `sample_valid` and `xtrig_out` are 0, `sample_data` is 0 and `seq_state` is 0 (idle).
- R2: While enabled with interval length L, an expiry happens on every L-th clock edge. The count starts on the first edge at which `enable` is sampled high and restarts after each expiry. At an expiry edge, `sample_data` takes the number of edges with `stall_in` high that were seen since the previous expiry (or since enable), not including the expiry edge itself.
- R3: `sample_valid` is 1 for exactly the one cycle that follows each expiry edge, and is 0 at all other times.
- R4: A stall sampled on an expiry edge is not part of the sample taken on that edge. It is counted as the first stall of the next interval.
- R5: An `interval_len` of 0 behaves like 1: every enabled edge is an expiry.
- R6: `seq_state` is encoded as idle=0, DMA-started=1 and stall=2. The value 3 never appears. From idle, an edge with `mem_access_in` high moves the sequencer to DMA-started.
- R7: From DMA-started, an edge with `stall_in` high moves the sequencer to stall. `xtrig_out` is 1 in exactly the one cycle in which `seq_state` first shows stall.
- R8: In the stall state, an expiry edge returns the sequencer to idle. `mem_access_in` and `stall_in` do not change the state while in stall.
- R9: In idle, `stall_in` alone does not move the sequencer. In DMA-started, `mem_access_in` and expiry do not move it.
- R10: While `enable` is low, the interval timer and the count are cleared and the sequencer is held in idle. `sample_valid` and `xtrig_out` stay 0, and `sample_data` keeps its last value.
- R11: The running count saturates at 2^CW-1 and does not wrap.
- R12: A new `interval_len` takes effect at once. If the cycles already elapsed in the current interval reach the new length, the next enabled edge is an expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Gates counting, timer and sequencer |
| interval_len | input | TW | Sampling interval in cycles (0 behaves as 1) |
| stall_in | input | 1 | Stall trigger, one count per high cycle |
| mem_access_in | input | 1 | Memory-access event from a bus monitor |
| sample_data | output | CW | Count snapshot of the last interval |
| sample_valid | output | 1 | One-cycle strobe for a new snapshot |
| xtrig_out | output | 1 | Cross-trigger pulse on entry to stall state |
| seq_state | output | 2 | Sequencer state (0 idle, 1 DMA-started, 2 stall) |

## Verification
The counter is driven with four stall patterns, each separating a different behaviour:
- A continuous stall separates the shorter first interval after enable from the full-length intervals that follow.
- Stalls placed only on expiry edges show whether a boundary stall goes into the old sample or the new interval.
- A long continuous stall over a wide interval shows saturation against wrap-around.
- A length cut in the middle of an interval shows whether the new limit is applied at once.

The sequencer is fed events that are illegal in each state, such as a stall in idle or a memory access in DMA-started, to show which inputs each state ignores. Dropping `enable` while the sequencer is active shows whether everything is cleared.

// File: rtl/ism_pkg.sv
package ism_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_DMA   = 2'd1,
    SEQ_STALL = 2'd2
  } seq_state_e;
endpackage

// File: rtl/ism_interval_timer.sv
module ism_interval_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [TW-1:0] period,
  output logic          expiry
);
  logic [TW-1:0] elapsed;

  // A programmed period of zero is treated as one cycle.
  function automatic logic [TW-1:0] eff_period(input logic [TW-1:0] p);
    return (p == '0) ? TW'(1) : p;
  endfunction

  // Greater-or-equal, so that shortening the period takes effect at once.
  function automatic logic reached(input logic [TW-1:0] e, input logic [TW-1:0] p);
    return e >= (eff_period(p) - TW'(1));
  endfunction

  assign expiry = enable && reached(elapsed, period);

  always_ff @(posedge clk) begin
    if (!rst_n)                 elapsed <= '0;
    else if (!enable || expiry) elapsed <= '0;
    else                        elapsed <= elapsed + TW'(1);
  end
endmodule

// File: rtl/ism_stall_counter.sv
module ism_stall_counter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          expiry,
  input  logic          stall,
  output logic [CW-1:0] count,
  output logic [CW-1:0] sample_data,
  output logic          sample_valid
);
  localparam logic [CW-1:0] CNT_MAX = '1;

  function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] c);
    return (c == CNT_MAX) ? c : c + CW'(1);
  endfunction

  // A stall on the expiry edge opens the next interval.
  always_ff @(posedge clk) begin
    if (!rst_n)       count <= '0;
    else if (!enable) count <= '0;
    else if (expiry)  count <= stall ? CW'(1) : '0;
    else if (stall)   count <= sat_inc(count);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sample_data  <= '0;
      sample_valid <= 1'b0;
    end else begin
      sample_valid <= expiry;
      if (expiry) sample_data <= count;
    end
  end
endmodule

// File: rtl/ism_sequencer.sv
module ism_sequencer
  import ism_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       mem_access,
  input  logic       stall,
  input  logic       expiry,
  output seq_state_e state,
  output logic       enter_stall,
  output logic       xtrig
);
  seq_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      SEQ_IDLE:  if (mem_access) nxt = SEQ_DMA;
      SEQ_DMA:   if (stall)      nxt = SEQ_STALL;
      SEQ_STALL: if (expiry)     nxt = SEQ_IDLE;
      default:                   nxt = SEQ_IDLE;
    endcase
  end

  assign enter_stall = enable && (state == SEQ_DMA) && (nxt == SEQ_STALL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= SEQ_IDLE;
      xtrig <= 1'b0;
    end else if (!enable) begin
      state <= SEQ_IDLE;
      xtrig <= 1'b0;
    end else begin
      state <= nxt;
      xtrig <= enter_stall;
    end
  end
endmodule

// File: rtl/ism_status_monitor.sv
module ism_status_monitor
  import ism_pkg::*;
#(
  parameter int CW = 8,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [TW-1:0] interval_len,
  input  logic          stall_in,
  input  logic          mem_access_in,
  output logic [CW-1:0] sample_data,
  output logic          sample_valid,
  output logic          xtrig_out,
  output logic [1:0]    seq_state
);
  logic          tmr_expiry;
  logic [CW-1:0] stall_count;
  logic          seq_enter_stall;
  seq_state_e    seq_q;

  ism_interval_timer #(.TW(TW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (enable),
    .period (interval_len),
    .expiry (tmr_expiry)
  );

  ism_stall_counter #(.CW(CW)) u_count (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .expiry       (tmr_expiry),
    .stall        (stall_in),
    .count        (stall_count),
    .sample_data  (sample_data),
    .sample_valid (sample_valid)
  );

  ism_sequencer u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .mem_access  (mem_access_in),
    .stall       (stall_in),
    .expiry      (tmr_expiry),
    .state       (seq_q),
    .enter_stall (seq_enter_stall),
    .xtrig       (xtrig_out)
  );

  assign seq_state = seq_q;
endmodule

// File: rtl/ism_status_monitor_sva.sv
module ism_status_monitor_sva #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enable,
  input logic          expiry,
  input logic          enter_stall,
  input logic [CW-1:0] count,
  input logic          sample_valid,
  input logic          xtrig_out,
  input logic [1:0]    seq_state
);
  localparam logic [CW-1:0] CNT_TOP = '1;

  assert_sample_after_expiry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    expiry |=> sample_valid);

  assert_sample_needs_expiry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |-> $past(expiry));

  assert_state_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    seq_state != 2'd3);

  assert_xtrig_on_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    xtrig_out |-> (seq_state == 2'd2 && $past(seq_state) == 2'd1));

  assert_entry_fires_xtrig_R7: assert property (@(posedge clk) disable iff (!rst_n)
    enter_stall |=> xtrig_out);

  assert_stall_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && seq_state == 2'd2 && expiry) |=> seq_state == 2'd0);

  assert_quiet_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (seq_state == 2'd0 && !xtrig_out && !sample_valid));

  assert_count_saturates_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !expiry && count == CNT_TOP) |=> count == CNT_TOP);
endmodule

bind ism_status_monitor ism_status_monitor_sva #(.CW(CW)) u_sva (
  .clk          (clk),
  .rst_n        (rst_n),
  .enable       (enable),
  .expiry       (tmr_expiry),
  .enter_stall  (seq_enter_stall),
  .count        (stall_count),
  .sample_valid (sample_valid),
  .xtrig_out    (xtrig_out),
  .seq_state    (seq_state)
);

// File: tb/ism_status_monitor_test.sv
module ism_status_monitor_test;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 8;
  localparam int TW = 16;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enable = 1'b0;
  logic [TW-1:0] interval_len = '0;
  logic          stall_in = 1'b0;
  logic          mem_access_in = 1'b0;
  logic [CW-1:0] sample_data;
  logic          sample_valid;
  logic          xtrig_out;
  logic [1:0]    seq_state;

  int compared = 0;
  int mismatched = 0;

  // Drive values and the bench's own expectation model.
  logic en_drv = 1'b0;
  int   len_drv = 0;
  int   ph = 0, acc = 0, m_state = 0, m_data = 0;
  logic m_valid = 1'b0, m_x = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ism_status_monitor #(.CW(CW), .TW(TW)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .interval_len(interval_len),
    .stall_in(stall_in), .mem_access_in(mem_access_in), .sample_data(sample_data),
    .sample_valid(sample_valid), .xtrig_out(xtrig_out), .seq_state(seq_state)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Called at a negedge; applies inputs, waits one edge, checks at the next negedge.
  task automatic tick(input logic st, input logic mem);
    stall_in = st; mem_access_in = mem; enable = en_drv; interval_len = TW'(len_drv);
    @(posedge clk);
    if (!en_drv) begin
      ph = 0; acc = 0; m_valid = 1'b0; m_x = 1'b0; m_state = 0;
    end else begin
      int  eff = (len_drv == 0) ? 1 : len_drv;
      logic hit = (ph + 1 >= eff);
      m_valid = hit;
      m_x = (m_state == 1) && st;
      if (m_state == 0 && mem)      m_state = 1;
      else if (m_state == 1 && st)  m_state = 2;
      else if (m_state == 2 && hit) m_state = 0;
      if (hit) begin m_data = acc; acc = st ? 1 : 0; ph = 0; end
      else begin ph++; if (st && acc < CMAX) acc++; end
    end
    @(negedge clk);
    check("R3", "sample_valid", sample_valid, m_valid);
    check("R2", "sample_data", sample_data, m_data);
    check("R7", "xtrig_out", xtrig_out, m_x);
    check("R6", "seq_state", seq_state, m_state);
  endtask

  task automatic restart(input int len);
    en_drv = 1'b0; tick(0, 0);
    en_drv = 1'b1; len_drv = len;
  endtask

  task automatic t_reset();
    check("R1", "valid in reset", sample_valid, 0);
    check("R1", "xtrig in reset", xtrig_out, 0);
    check("R1", "data in reset", sample_data, 0);
    check("R1", "state in reset", seq_state, 0);
    rst_n = 1'b1;
    tick(0, 0);
    check("R1", "state after reset", seq_state, 0);
  endtask

  task automatic t_periodic();
    restart(4);
    repeat (4) tick(1, 0);
    check("R2", "first interval count", sample_data, 3);
    check("R3", "strobe at expiry", sample_valid, 1);
    tick(1, 0);
    check("R3", "strobe one cycle", sample_valid, 0);
    repeat (3) tick(1, 0);
    check("R2", "full interval count", sample_data, 4);
  endtask

  task automatic t_boundary();
    restart(3);
    tick(0, 0); tick(0, 0); tick(1, 0);
    check("R4", "boundary stall excluded", sample_data, 0);
    tick(0, 0); tick(0, 0); tick(1, 0);
    check("R4", "boundary stall carried", sample_data, 1);
  endtask

  task automatic t_len_zero();
    restart(0);
    tick(1, 0);
    check("R5", "len0 first", sample_valid, 1);
    tick(1, 0);
    check("R5", "len0 every cycle", sample_valid, 1);
    check("R5", "len0 count", sample_data, 1);
  endtask

  task automatic t_sequencer();
    restart(8);
    tick(1, 0);
    check("R9", "stall ignored in idle", seq_state, 0);
    tick(0, 1);
    check("R6", "idle to dma", seq_state, 1);
    tick(0, 1);
    check("R9", "mem ignored in dma", seq_state, 1);
    tick(1, 0);
    check("R7", "dma to stall", seq_state, 2);
    check("R7", "xtrig on entry", xtrig_out, 1);
    tick(0, 0);
    check("R7", "xtrig single", xtrig_out, 0);
    tick(1, 1);
    check("R8", "inputs ignored in stall", seq_state, 2);
    tick(0, 0);
    tick(0, 0);
    check("R8", "expiry leaves stall", seq_state, 0);
  endtask

  task automatic t_disable();
    restart(1);
    tick(0, 1);
    check("R10", "setup dma", seq_state, 1);
    en_drv = 1'b0;
    tick(1, 1);
    check("R10", "idle when off", seq_state, 0);
    repeat (3) tick(1, 1);
    check("R10", "no strobe when off", sample_valid, 0);
    check("R10", "no xtrig when off", xtrig_out, 0);
  endtask

  task automatic t_saturate();
    restart(300);
    repeat (300) tick(1, 0);
    check("R11", "saturated sample", sample_data, CMAX);
    check("R11", "saturated strobe", sample_valid, 1);
  endtask

  task automatic t_shrink();
    restart(10);
    repeat (3) tick(1, 0);
    len_drv = 2;
    tick(0, 0);
    check("R12", "shrink expires at once", sample_valid, 1);
    check("R12", "shrink sample", sample_data, 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_periodic();
    t_boundary();
    t_len_zero();
    t_sequencer();
    t_disable();
    t_saturate();
    t_shrink();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule